// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen 32-bit general registers of a small processor that runs in one of four modes: user, fast interrupt, interrupt and supervisor. The mode picks which physical copy stands behind the upper register numbers. Fast-interrupt mode swaps in private copies of registers 8 to 14. Interrupt and supervisor modes each swap in private copies of registers 13 and 14 only. Registers 0 to 7 are always shared. Register 15 is not a plain storage word. It packs the condition flags, the two interrupt masks, a word-aligned program address and the two-bit mode field into one value.

An execution pipeline uses the block through two combinational read ports and one write port, all indexed by architectural register number. A separate update interface loads the program address and the status field, for example on a sequential fetch or a flag-setting result. A force-user input sends every read and write to the user-mode copies, whatever the current mode. Block transfers in a privileged mode use it to reach user registers. The interrupt masks and the mode can only be changed while the processor is in a privileged mode. Once user mode is entered, only a reset leaves it.

Top module: `mode_banked_regfile`

## Requirements
- R1: After reset, register 15 reads 0x0C000003: flags clear, both interrupt masks set, address zero and mode supervisor. Every other register reads zero.
- R2: Register 15 is laid out with bit 31 = N, 30 = Z, 29 = C, 28 = V, 27 = interrupt mask, 26 = fast-interrupt mask, bits 25:2 = word address and bits 1:0 = mode. Reading index 15 on either port returns this word.
- R3: The mode encoding is 00 user, 01 fast interrupt, 10 interrupt, 11 supervisor. Fast-interrupt mode has private registers 8 to 14. Interrupt and supervisor modes each have private registers 13 and 14. All other numbers resolve to the user copies.
- R4: The two read ports are combinational and independent. Two ports given the same index return the same value.
- R5: While force_user is high, reads and writes of indices 0 to 14 use the user-mode copies. The banked copies of the current mode are left untouched.
- R6: A write-port write to index 15 replaces only the address field with wr_data[25:2]. Flags, masks and mode change only if wr_st is also high, in which case they are taken from wr_data[31:26] and wr_data[1:0]. With no write to 15 and no update strobe, register 15 holds its value.
- R7: upd_pc_en loads the address field from upd_pc_addr. upd_st_en loads the status from upd_st_val, laid out as {N,Z,C,V,I,F,mode[1:0]}.
- R8: In user mode, status writes change N, Z, C and V but leave both interrupt masks and the mode unchanged. From a privileged mode, all eight status bits are written.
- R9: When the write port targets index 15 in the same cycle as the update interface, the write port wins for the address field. When wr_st is high, it also wins for the status field.
- R10: A mode change becomes visible in the next cycle. A register write in the same cycle as a mode change lands in the bank of the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A value |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B value |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port register number |
| wr_data | input | 32 | Write port data |
| wr_st | input | 1 | Status strobe for a write to index 15 |
| force_user | input | 1 | Route reads and writes to the user copies |
| upd_pc_en | input | 1 | Load the address field |
| upd_pc_addr | input | 24 | New word address |
| upd_st_en | input | 1 | Load the status field |
| upd_st_val | input | 8 | New status {N,Z,C,V,I,F,mode} |
| r15_word | output | 32 | Current packed register 15 |

## Verification
A write-port write to register 15 can fall in the same cycle as an update-interface load of the address or the status. A mode change can also fall in the same cycle as a banked register write. Directed cycles drive each pair together with different values. The random phase raises both strobes often enough that they collide many times. A reference model that keeps every bank separately judges each case: it picks the write-port field and resolves the written register through the mode held before the edge. Every following read is compared against that model on both ports, with and without force_user.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned IDX_W  = 4;
   localparam int unsigned ADDR_W = 24;
   localparam int unsigned ST_W   = 8;

   typedef enum logic [1:0] {
      MODE_USR = 2'b00,
      MODE_FIQ = 2'b01,
      MODE_IRQ = 2'b10,
      MODE_SVC = 2'b11
   } mode_e;

   // Field order matches the packed bit layout, top bit first.
   typedef struct packed {
      logic [3:0]        nzcv;
      logic [1:0]        mask;   // {interrupt mask, fast-interrupt mask}
      logic [ADDR_W-1:0] addr;
      mode_e             mode;
   } r15_t;
endpackage

// File: rtl/rbk_index_map.sv
module rbk_index_map
   import rbk_pkg::*;
#(
   parameter int unsigned FIQ_LO  = 8,
   parameter int unsigned PRIV_LO = 13,
   parameter int unsigned PHYS_W  = 5
) (
   input  logic [IDX_W-1:0]  arch_idx,
   input  mode_e             mode,
   input  logic              force_user,
   output logic [PHYS_W-1:0] phys_idx,
   output logic              is_pc
);
   localparam int unsigned SHARED_N = 15;
   localparam int unsigned FIQ_N    = SHARED_N - FIQ_LO;
   localparam int unsigned PRIV_N   = SHARED_N - PRIV_LO;
   localparam int unsigned FIQ_BASE = SHARED_N;
   localparam int unsigned IRQ_BASE = FIQ_BASE + FIQ_N;
   localparam int unsigned SVC_BASE = IRQ_BASE + PRIV_N;
   localparam logic [IDX_W-1:0] FIQ_LO_I  = IDX_W'(FIQ_LO);
   localparam logic [IDX_W-1:0] PRIV_LO_I = IDX_W'(PRIV_LO);
   localparam logic [PHYS_W-1:0] FIQ_OFS = PHYS_W'(FIQ_BASE - FIQ_LO);
   localparam logic [PHYS_W-1:0] IRQ_OFS = PHYS_W'(IRQ_BASE - PRIV_LO);
   localparam logic [PHYS_W-1:0] SVC_OFS = PHYS_W'(SVC_BASE - PRIV_LO);

   mode_e bank;
   logic  in_fiq_rng, in_priv_rng;

   always_comb begin
      bank        = force_user ? MODE_USR : mode;
      is_pc       = (arch_idx == {IDX_W{1'b1}});
      in_fiq_rng  = (arch_idx >= FIQ_LO_I) && !is_pc;
      in_priv_rng = (arch_idx >= PRIV_LO_I) && !is_pc;
      phys_idx    = is_pc ? '0 : PHYS_W'(arch_idx);
      case (bank)
         MODE_FIQ: if (in_fiq_rng)  phys_idx = FIQ_OFS + PHYS_W'(arch_idx);
         MODE_IRQ: if (in_priv_rng) phys_idx = IRQ_OFS + PHYS_W'(arch_idx);
         MODE_SVC: if (in_priv_rng) phys_idx = SVC_OFS + PHYS_W'(arch_idx);
         default:  ;
      endcase
   end
endmodule

// File: rtl/rbk_store.sv
module rbk_store #(
   parameter int unsigned DEPTH       = 26,
   parameter int unsigned PHYS_W      = 5,
   parameter int unsigned WORD_W      = 32,
   parameter bit          RESET_STORE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [PHYS_W-1:0] wa,
   input  logic [WORD_W-1:0] wd,
   input  logic [PHYS_W-1:0] ra_a,
   output logic [WORD_W-1:0] rd_a,
   input  logic [PHYS_W-1:0] ra_b,
   output logic [WORD_W-1:0] rd_b
);
   logic [WORD_W-1:0] mem [DEPTH];

   generate
      if (RESET_STORE) begin : g_rst_store
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we && (int'(wa) < DEPTH)) begin
               mem[wa] <= wd;
            end
         end
      end else begin : g_plain_store
         logic unused_rst;
         assign unused_rst = rst;
         always_ff @(posedge clk) begin
            if (we && (int'(wa) < DEPTH)) mem[wa] <= wd;
         end
      end
   endgenerate

   assign rd_a = (int'(ra_a) < DEPTH) ? mem[ra_a] : '0;
   assign rd_b = (int'(ra_b) < DEPTH) ? mem[ra_b] : '0;
endmodule

// File: rtl/rbk_pc_status.sv
module rbk_pc_status
   import rbk_pkg::*;
#(
   parameter bit USER_NZCV_WR = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_hit,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              wr_st,
   input  logic              upd_pc_en,
   input  logic [ADDR_W-1:0] upd_pc_addr,
   input  logic              upd_st_en,
   input  logic [ST_W-1:0]   upd_st_val,
   output r15_t              cur
);
   localparam r15_t RST_VAL = '{nzcv: 4'b0000, mask: 2'b11, addr: '0, mode: MODE_SVC};

   r15_t            nxt;
   logic            priv, st_go, port_st;
   logic [ST_W-1:0] st_src;
   logic            nzcv_ok;

   generate
      if (USER_NZCV_WR) begin : g_nzcv_any
         assign nzcv_ok = 1'b1;
      end else begin : g_nzcv_priv
         assign nzcv_ok = priv;
      end
   endgenerate

   always_comb begin
      nxt     = cur;
      priv    = (cur.mode != MODE_USR);
      port_st = wr_hit && wr_st;
      st_go   = port_st || upd_st_en;
      st_src  = port_st ? {wr_data[31:26], wr_data[1:0]} : upd_st_val;
      if (wr_hit)         nxt.addr = wr_data[ADDR_W+1:2];
      else if (upd_pc_en) nxt.addr = upd_pc_addr;
      if (st_go) begin
         if (nzcv_ok) nxt.nzcv = st_src[7:4];
         if (priv) begin
            nxt.mask = st_src[3:2];
            nxt.mode = mode_e'(st_src[1:0]);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) cur <= RST_VAL;
      else     cur <= nxt;
   end
endmodule

// File: rtl/mode_banked_regfile.sv
module mode_banked_regfile
   import rbk_pkg::*;
#(
   parameter int unsigned FIQ_LO       = 8,
   parameter int unsigned PRIV_LO      = 13,
   parameter bit          RESET_STORE  = 1'b1,
   parameter bit          USER_NZCV_WR = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   input  logic [3:0]  rd_a_idx,
   output logic [31:0] rd_a_data,
   input  logic [3:0]  rd_b_idx,
   output logic [31:0] rd_b_data,
   input  logic        wr_en,
   input  logic [3:0]  wr_idx,
   input  logic [31:0] wr_data,
   input  logic        wr_st,
   input  logic        force_user,
   input  logic        upd_pc_en,
   input  logic [23:0] upd_pc_addr,
   input  logic        upd_st_en,
   input  logic [7:0]  upd_st_val,
   output logic [31:0] r15_word
);
   localparam int unsigned DEPTH  = 15 + (15 - FIQ_LO) + 2 * (15 - PRIV_LO);
   localparam int unsigned PHYS_W = $clog2(DEPTH);
   localparam int unsigned RD_N   = 2;

   generate
      if (FIQ_LO < 1 || FIQ_LO > PRIV_LO) begin : g_bad_fiq_lo
         $error("FIQ_LO must lie in 1..PRIV_LO");
      end
      if (PRIV_LO > 14) begin : g_bad_priv_lo
         $error("PRIV_LO must not exceed 14");
      end
   endgenerate

   r15_t              r15_q;
   logic [IDX_W-1:0]  rd_idx  [RD_N];
   logic [PHYS_W-1:0] rd_phys [RD_N];
   logic              rd_pc   [RD_N];
   logic [WORD_W-1:0] rd_mem  [RD_N];
   logic [WORD_W-1:0] rd_out  [RD_N];
   logic [PHYS_W-1:0] wr_phys;
   logic              wr_pc;

   assign rd_idx[0] = rd_a_idx;
   assign rd_idx[1] = rd_b_idx;

   genvar p;
   generate
      for (p = 0; p < RD_N; p++) begin : g_rd
         rbk_index_map #(.FIQ_LO(FIQ_LO), .PRIV_LO(PRIV_LO), .PHYS_W(PHYS_W)) u_map (
            .arch_idx   (rd_idx[p]),
            .mode       (r15_q.mode),
            .force_user (force_user),
            .phys_idx   (rd_phys[p]),
            .is_pc      (rd_pc[p])
         );
         assign rd_out[p] = rd_pc[p] ? r15_q : rd_mem[p];
      end
   endgenerate

   rbk_index_map #(.FIQ_LO(FIQ_LO), .PRIV_LO(PRIV_LO), .PHYS_W(PHYS_W)) u_wr_map (
      .arch_idx   (wr_idx),
      .mode       (r15_q.mode),
      .force_user (force_user),
      .phys_idx   (wr_phys),
      .is_pc      (wr_pc)
   );

   rbk_store #(.DEPTH(DEPTH), .PHYS_W(PHYS_W), .WORD_W(WORD_W), .RESET_STORE(RESET_STORE)) u_store (
      .clk  (clk),
      .rst  (rst),
      .we   (wr_en && !wr_pc),
      .wa   (wr_phys),
      .wd   (wr_data),
      .ra_a (rd_phys[0]),
      .rd_a (rd_mem[0]),
      .ra_b (rd_phys[1]),
      .rd_b (rd_mem[1])
   );

   rbk_pc_status #(.USER_NZCV_WR(USER_NZCV_WR)) u_r15 (
      .clk         (clk),
      .rst         (rst),
      .wr_hit      (wr_en && wr_pc),
      .wr_data     (wr_data),
      .wr_st       (wr_st),
      .upd_pc_en   (upd_pc_en),
      .upd_pc_addr (upd_pc_addr),
      .upd_st_en   (upd_st_en),
      .upd_st_val  (upd_st_val),
      .cur         (r15_q)
   );

   assign rd_a_data = rd_out[0];
   assign rd_b_data = rd_out[1];
   assign r15_word  = r15_q;
endmodule

// File: rtl/rbk_sva.sv
module rbk_sva (
   input logic        clk,
   input logic        rst,
   input logic [3:0]  rd_a_idx,
   input logic [31:0] rd_a_data,
   input logic [3:0]  rd_b_idx,
   input logic [31:0] rd_b_data,
   input logic        wr_en,
   input logic [3:0]  wr_idx,
   input logic [31:0] wr_data,
   input logic        wr_st,
   input logic        upd_pc_en,
   input logic        upd_st_en,
   input logic [31:0] r15_word
);
   logic wr15;
   assign wr15 = wr_en && (wr_idx == 4'd15);

   p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (r15_word == 32'h0C00_0003));

   p_pc_read_a_r2: assert property (@(posedge clk) disable iff (rst)
      (rd_a_idx == 4'd15) |-> (rd_a_data == r15_word));

   p_pc_read_b_r2: assert property (@(posedge clk) disable iff (rst)
      (rd_b_idx == 4'd15) |-> (rd_b_data == r15_word));

   p_same_index_r4: assert property (@(posedge clk) disable iff (rst)
      (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));

   p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!wr15 && !upd_pc_en) |=> $stable(r15_word[25:2]));

   p_status_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!(wr15 && wr_st) && !upd_st_en) |=> ($stable(r15_word[31:26]) && $stable(r15_word[1:0])));

   p_user_locked_r8: assert property (@(posedge clk) disable iff (rst)
      (r15_word[1:0] == 2'b00) |=> ((r15_word[1:0] == 2'b00) && $stable(r15_word[27:26])));

   p_port_wins_r9: assert property (@(posedge clk) disable iff (rst)
      wr15 |=> (r15_word[25:2] == $past(wr_data[25:2])));
endmodule

bind mode_banked_regfile rbk_sva u_sva (.*);

// File: tb/tb_mode_banked_regfile.sv
`timescale 1ns/1ps
module tb_mode_banked_regfile;
   logic        clk = 1'b0;
   logic        rst;
   logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
   logic [31:0] rd_a_data, rd_b_data, wr_data, r15_word;
   logic        wr_en, wr_st, force_user, upd_pc_en, upd_st_en;
   logic [23:0] upd_pc_addr;
   logic [7:0]  upd_st_val;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   mode_banked_regfile dut (.*);

   // Reference model: each bank kept apart.
   logic [31:0] m_usr [15];
   logic [31:0] m_fiq [7];
   logic [31:0] m_irq [2];
   logic [31:0] m_svc [2];
   logic [3:0]  m_nzcv;
   logic [1:0]  m_mask, m_mode;
   logic [23:0] m_addr;

   function automatic logic [31:0] m_r15();
      return {m_nzcv, m_mask, m_addr, m_mode};
   endfunction

   function automatic logic [31:0] m_read(int idx, bit fu);
      logic [1:0] bk;
      bk = fu ? 2'b00 : m_mode;
      if (idx == 15) return m_r15();
      if (bk == 2'b01 && idx >= 8)  return m_fiq[idx-8];
      if (bk == 2'b10 && idx >= 13) return m_irq[idx-13];
      if (bk == 2'b11 && idx >= 13) return m_svc[idx-13];
      return m_usr[idx];
   endfunction

   task automatic m_write(int idx, logic [31:0] d, bit fu);
      logic [1:0] bk;
      bk = fu ? 2'b00 : m_mode;
      if (bk == 2'b01 && idx >= 8)       m_fiq[idx-8]  = d;
      else if (bk == 2'b10 && idx >= 13) m_irq[idx-13] = d;
      else if (bk == 2'b11 && idx >= 13) m_svc[idx-13] = d;
      else                               m_usr[idx]    = d;
   endtask

   task automatic m_reset();
      foreach (m_usr[i]) m_usr[i] = '0;
      foreach (m_fiq[i]) m_fiq[i] = '0;
      foreach (m_irq[i]) m_irq[i] = '0;
      foreach (m_svc[i]) m_svc[i] = '0;
      m_nzcv = '0; m_mask = 2'b11; m_addr = '0; m_mode = 2'b11;
   endtask

   task automatic m_commit();
      bit         priv, hit15, go;
      logic [7:0] src;
      if (rst) begin
         m_reset();
         return;
      end
      priv  = (m_mode != 2'b00);
      hit15 = wr_en && (wr_idx == 4'd15);
      if (wr_en && !hit15) m_write(int'(wr_idx), wr_data, force_user);
      if (hit15)          m_addr = wr_data[25:2];
      else if (upd_pc_en) m_addr = upd_pc_addr;
      go  = (hit15 && wr_st) || upd_st_en;
      src = (hit15 && wr_st) ? {wr_data[31:26], wr_data[1:0]} : upd_st_val;
      if (go) begin
         m_nzcv = src[7:4];
         if (priv) begin
            m_mask = src[3:2];
            m_mode = src[1:0];
         end
      end
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      wr_en = 0; wr_idx = 0; wr_data = 0; wr_st = 0; force_user = 0;
      upd_pc_en = 0; upd_pc_addr = 0; upd_st_en = 0; upd_st_val = 0;
      rd_a_idx = 0; rd_b_idx = 0;
   endtask

   task automatic tick();
      @(posedge clk);
      m_commit();
      @(negedge clk);
   endtask

   // Sweep every index on both ports, own bank and forced user bank.
   task automatic check_all(string req);
      for (int fu = 0; fu < 2; fu++) begin
         for (int i = 0; i < 16; i++) begin
            force_user = fu[0];
            rd_a_idx   = 4'(i);
            rd_b_idx   = 4'(15 - i);
            #0.04;
            chk(req, rd_a_data, m_read(i, fu[0]));
            chk(req, rd_b_data, m_read(15 - i, fu[0]));
         end
      end
      force_user = 0;
   endtask

   task automatic wr(int idx, logic [31:0] d, bit fu);
      wr_en = 1; wr_idx = 4'(idx); wr_data = d; force_user = fu;
      tick();
      idle();
   endtask

   task automatic set_st(logic [7:0] v);
      upd_st_en = 1; upd_st_val = v;
      tick();
      idle();
   endtask

   task automatic do_reset();
      rst = 1;
      tick();
      tick();
      rst = 0;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int stuck;
      void'($urandom(32'd1357));
      idle();
      rst = 1;
      m_reset();
      @(negedge clk);
      do_reset();

      // R1: reset state
      #0.1 chk("R1", r15_word, 32'h0C00_0003);
      check_all("R1");

      // R3 / R5: fill the user bank through force_user, then each mode's bank
      for (int i = 8; i < 15; i++) wr(i, 32'h5500_0000 + i, 1'b1);
      for (int i = 8; i < 15; i++) wr(i, 32'h3300_0000 + i, 1'b0);   // supervisor
      check_all("R5");
      set_st(8'b0000_1110);                                            // interrupt mode
      chk("R3", r15_word, m_r15());
      for (int i = 8; i < 15; i++) wr(i, 32'h2200_0000 + i, 1'b0);
      check_all("R3");
      set_st(8'b0000_1101);                                            // fast interrupt
      for (int i = 8; i < 15; i++) wr(i, 32'h1100_0000 + i, 1'b0);
      check_all("R3");
      wr(10, 32'hABCD_0010, 1'b1);                                     // R5: forced write in fast mode
      check_all("R5");
      set_st(8'b0000_1111);                                            // back to supervisor
      check_all("R3");

      // R6: address-only write to 15
      wr(15, 32'hFFFF_FFFC, 1'b0);
      chk("R6", r15_word, 32'h0FFF_FFFF);
      // R6: write to 15 with status strobe
      wr_st = 1;
      wr(15, 32'hA400_0012, 1'b0);
      chk("R6", r15_word, 32'hA400_0012);

      // R7: update interface
      upd_pc_en = 1; upd_pc_addr = 24'h123456;
      tick(); idle();
      chk("R7", r15_word, m_r15());
      set_st(8'b0110_1111);
      chk("R7", r15_word, 32'h6C48_D15B);

      // R9: same-cycle port write to 15 against update interface
      wr_en = 1; wr_idx = 15; wr_data = 32'h5000_0AA7; wr_st = 1;
      upd_pc_en = 1; upd_pc_addr = 24'h00FFFF;
      upd_st_en = 1; upd_st_val = 8'b1111_1101;
      tick(); idle();
      chk("R9", r15_word, 32'h5000_0AA7);
      wr_en = 1; wr_idx = 15; wr_data = 32'h0000_0100; wr_st = 0;
      upd_st_en = 1; upd_st_val = 8'b1000_0011;
      tick(); idle();
      chk("R9", r15_word, 32'h8000_0103);

      // R10: mode change and banked write in the same cycle
      upd_st_en = 1; upd_st_val = 8'b0000_0010;
      wr_en = 1; wr_idx = 13; wr_data = 32'hC0DE_0013;
      tick(); idle();
      chk("R10", r15_word[1:0], 32'h2);
      check_all("R10");

      // R8: enter user mode, then attempt to raise masks and mode
      set_st(8'b1010_0000);
      set_st(8'b0101_1111);
      chk("R8", r15_word, {4'b0101, 2'b00, m_addr, 2'b00});
      check_all("R8");

      // Random phase
      do_reset();
      stuck = 0;
      for (int n = 0; n < 4000; n++) begin
         wr_en       = ($urandom % 2) == 0;
         wr_idx      = 4'($urandom);
         wr_data     = $urandom;
         wr_st       = ($urandom % 4) == 0;
         force_user  = ($urandom % 4) == 0;
         upd_pc_en   = ($urandom % 2) == 0;
         upd_pc_addr = 24'($urandom);
         upd_st_en   = ($urandom % 6) == 0;
         upd_st_val  = 8'($urandom);
         rd_a_idx    = 4'($urandom);
         rd_b_idx    = 4'($urandom);
         #1;
         chk("R4", rd_a_data, m_read(int'(rd_a_idx), force_user));
         chk("R4", rd_b_data, m_read(int'(rd_b_idx), force_user));
         chk("R2", r15_word, m_r15());
         tick();
         idle();
         stuck = (m_mode == 2'b00) ? stuck + 1 : 0;
         if (stuck > 40) begin
            do_reset();
            stuck = 0;
         end
      end
      check_all("R3");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule